// File: doc/BRIEF.md
# Single-Channel Serial Port with Register Interface

This block is one asynchronous serial channel behind a small word-addressed register window. Software writes a character into a one-entry transmit holding register. When the shifter is free, the character moves into a transmit shift register, which sends it as a start bit, eight data bits with the least significant bit first, an optional parity bit and one stop bit. A receive state machine oversamples the incoming line eight times per bit and takes each bit at mid-bit. It places every finished character into a one-entry receive buffer and raises sticky status flags for data ready, overrun, parity, framing and break.

The bit clock comes from a down-counter that reloads from the scaler register. Control bits enable the receiver and transmitter and their two interrupt pulses. They also turn on parity and select its polarity, turn on clear-to-send/request-to-send flow control, and select an internal loopback that feeds the transmit line into the receiver. A chip may place two instances 0x10 bytes apart to obtain two channels. Each instance decodes only the word index inside its own 16-byte window.

Top module: `sio_channel`

## Requirements
- R1: Word index 0 is data, 1 is status, 2 is control and 3 is scaler. Control (8 bits) and scaler read back what was written. After reset, data, control and scaler read 0 and status reads 0x06.
- R2: The oversampling tick occurs once every scaler+1 clocks, and each transmitted bit after the start bit lasts 8 ticks, which is 8*(scaler+1) clocks. A frame is a low start bit, data bits 7:0 sent LSB first, an optional parity bit, then one high stop bit.
- R3: Status bit 2 (holding empty) is 0 from the data write until the character moves to the shifter. Status bit 1 (shifter empty) is 0 while a frame is on the line. When no frame is being sent, txd is high.
- R4: With control bit 1 (transmit enable) clear, a written character stays in the holding register and txd stays high.
- R5: With control bit 6 (flow control) set, a waiting character is not moved to the shifter while cts_n is high. rts_n is high exactly when flow control is on and data ready is set.
- R6: With control bit 7 (loopback) set, the receiver sees the transmit line and the txd pin stays high.
- R7: With control bit 0 (receive enable) set, a finished character appears in data bits 7:0 and sets status bit 0 (data ready). Reading the data register clears data ready. With receive enable clear, line activity does not set data ready.
- R8: With control bit 5 set, a parity bit follows the data. Its value is the XOR of the data bits, inverted when control bit 4 is set (odd parity). A received parity bit that differs from this value sets status bit 5.
- R9: A low stop bit sets status bit 6 (framing error) if any data bit was 1. It sets status bit 3 (break) instead when all data bits were 0.
- R10: A character that finishes while data ready is set sets status bit 4 (overrun), and the buffer keeps the earlier character.
- R11: Writing zero to status clears data ready and bits 3 to 6. Writing any non-zero value to status changes nothing.
- R12: rx_irq is a one-cycle pulse when data ready rises and control bit 2 is set. tx_irq is a one-cycle pulse when the holding register empties into the shifter and control bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index inside the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Request to send, active low |
| rx_irq | output | 1 | Receive interrupt pulse |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
Bad receiver sampling state does not show up at once. It appears one frame later, as a wrong character in the data word or a spurious parity, framing or break flag in status. A stuck holding-full flag or a stuck shifter is visible within a few clocks in status bits 1 and 2, and on txd staying high. A wrong baud count shows as a data bit whose low period is not exactly eight tick periods, so the bench times one such bit on txd. Flag handling, meaning overrun keeping the old character and the zero-only clear, is checked by reading status and data right after the second character lands.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int CHAR_W  = 8;
    localparam int OVS     = 8;
    localparam int SUB_W   = $clog2(OVS);
    localparam int IDX_W   = $clog2(CHAR_W);
    localparam int FRAME_W = CHAR_W + 3;

    typedef enum logic [1:0] {
        W_DATA = 2'd0,
        W_STAT = 2'd1,
        W_CTRL = 2'd2,
        W_SCAL = 2'd3
    } word_e;

    // bit 7 .. bit 0 of the control word
    typedef struct packed {
        logic loop_en;
        logic flow_en;
        logic par_en;
        logic par_odd;
        logic tx_ie;
        logic rx_ie;
        logic tx_en;
        logic rx_en;
    } ctrl_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_REARM
    } rx_state_e;

    typedef struct packed {
        logic brk;
        logic parity;
        logic framing;
    } rx_err_t;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int SCALER_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SCALER_W-1:0] reload,
    output logic                tick
);
    typedef struct packed {
        logic [SCALER_W-1:0] cnt;
        logic                tick;
    } baud_t;

    baud_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == '0) begin
            st_d.cnt  = reload;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [CHAR_W-1:0] din,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              busy,
    output logic              line
);
    localparam int LEFT_W = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [LEFT_W-1:0]  left;
        logic [SUB_W-1:0]   sub;
        logic               busy;
    } tx_t;

    tx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (load) begin
                st_d.busy = 1'b1;
                st_d.sub  = '0;
                st_d.sh   = {1'b1, (par_en ? ((^din) ^ par_odd) : 1'b1), din, 1'b0};
                st_d.left = par_en ? LEFT_W'(FRAME_W) : LEFT_W'(FRAME_W - 1);
            end
        end else if (tick) begin
            st_d.sub = st_q.sub + 1'b1;
            if (st_q.sub == SUB_W'(OVS - 1)) begin
                st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
                st_d.left = st_q.left - 1'b1;
                if (st_q.left == LEFT_W'(1)) st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign line = st_q.busy ? st_q.sh[0] : 1'b1;
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              line,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done,
    output logic [CHAR_W-1:0] data,
    output rx_err_t           err
);
    typedef struct packed {
        rx_state_e         state;
        logic [SUB_W-1:0]  sub;
        logic [IDX_W-1:0]  idx;
        logic [CHAR_W-1:0] sh;
        logic              par_bad;
        logic              done;
        logic [CHAR_W-1:0] data;
        rx_err_t           err;
    } rx_t;

    rx_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!enable) begin
            st_d.state = RX_IDLE;
            st_d.sub   = '0;
        end else if (st_q.state == RX_REARM) begin
            if (line) st_d.state = RX_IDLE;
        end else if (tick) begin
            st_d.sub = st_q.sub + 1'b1;
            case (st_q.state)
                RX_IDLE: begin
                    st_d.sub = '0;
                    if (!line) st_d.state = RX_START;
                end
                RX_START: begin
                    if (st_q.sub == SUB_W'(OVS / 2 - 1)) begin
                        st_d.sub     = '0;
                        st_d.idx     = '0;
                        st_d.par_bad = 1'b0;
                        st_d.state   = line ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (st_q.sub == SUB_W'(OVS - 1)) begin
                        st_d.sh  = {line, st_q.sh[CHAR_W-1:1]};
                        st_d.idx = st_q.idx + 1'b1;
                        if (st_q.idx == IDX_W'(CHAR_W - 1))
                            st_d.state = par_en ? RX_PAR : RX_STOP;
                    end
                end
                RX_PAR: begin
                    if (st_q.sub == SUB_W'(OVS - 1)) begin
                        st_d.par_bad = line ^ (^st_q.sh) ^ par_odd;
                        st_d.state   = RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (st_q.sub == SUB_W'(OVS - 1)) begin
                        st_d.done        = 1'b1;
                        st_d.data        = st_q.sh;
                        st_d.err.framing = !line && (st_q.sh != '0);
                        st_d.err.brk     = !line && (st_q.sh == '0);
                        st_d.err.parity  = par_en && st_q.par_bad;
                        st_d.state       = line ? RX_IDLE : RX_REARM;
                    end
                end
                default: st_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign data = st_q.data;
    assign err  = st_q.err;
endmodule

// File: rtl/sio_channel.sv
module sio_channel
    import sio_pkg::*;
#(
    parameter int SCALER_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rxd,
    input  logic        cts_n,
    output logic        txd,
    output logic        rts_n,
    output logic        rx_irq,
    output logic        tx_irq
);
    typedef struct packed {
        ctrl_t               ctrl;
        logic [SCALER_W-1:0] scaler;
        logic [CHAR_W-1:0]   hold;
        logic                hold_full;
        logic [CHAR_W-1:0]   rx_buf;
        logic                dr;
        logic                ovr;
        logic                brk;
        logic                perr;
        logic                ferr;
        logic                rx_irq;
        logic                tx_irq;
        logic [1:0]          rxd_sync;
        logic [1:0]          cts_sync;
    } chan_t;

    chan_t st_d, st_q;

    logic              tick;
    logic              tx_busy;
    logic              tx_line;
    logic              tx_go;
    logic              rx_line;
    logic              rx_done;
    logic [CHAR_W-1:0] rx_data;
    rx_err_t           rx_err;
    logic              acc_wr, acc_rd;
    logic              cts_ok;

    // aliases for the bound checker
    logic              loop_en_w, flow_en_w, hold_full_w, dr_w, ovr_w;
    logic [CHAR_W-1:0] rx_buf_w;

    sio_baud #(.SCALER_W(SCALER_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (st_q.scaler),
        .tick   (tick)
    );

    sio_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (tx_go),
        .din     (st_q.hold),
        .par_en  (st_q.ctrl.par_en),
        .par_odd (st_q.ctrl.par_odd),
        .busy    (tx_busy),
        .line    (tx_line)
    );

    sio_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .enable  (st_q.ctrl.rx_en),
        .line    (rx_line),
        .par_en  (st_q.ctrl.par_en),
        .par_odd (st_q.ctrl.par_odd),
        .done    (rx_done),
        .data    (rx_data),
        .err     (rx_err)
    );

    assign acc_wr  = bus_sel && bus_wr;
    assign acc_rd  = bus_sel && !bus_wr;
    assign cts_ok  = !st_q.ctrl.flow_en || !st_q.cts_sync[1];
    assign tx_go   = st_q.hold_full && st_q.ctrl.tx_en && !tx_busy && cts_ok;
    assign rx_line = st_q.ctrl.loop_en ? tx_line : st_q.rxd_sync[1];

    always_comb begin
        st_d          = st_q;
        st_d.rxd_sync = {st_q.rxd_sync[0], rxd};
        st_d.cts_sync = {st_q.cts_sync[0], cts_n};

        if (acc_wr && bus_addr == W_CTRL) st_d.ctrl   = ctrl_t'(bus_wdata[CHAR_W-1:0]);
        if (acc_wr && bus_addr == W_SCAL) st_d.scaler = bus_wdata[SCALER_W-1:0];

        if (tx_go) st_d.hold_full = 1'b0;
        if (acc_wr && bus_addr == W_DATA) begin
            st_d.hold      = bus_wdata[CHAR_W-1:0];
            st_d.hold_full = 1'b1;
        end

        if (acc_rd && bus_addr == W_DATA) st_d.dr = 1'b0;
        if (acc_wr && bus_addr == W_STAT && bus_wdata == '0) begin
            st_d.dr   = 1'b0;
            st_d.ovr  = 1'b0;
            st_d.brk  = 1'b0;
            st_d.perr = 1'b0;
            st_d.ferr = 1'b0;
        end

        if (rx_done) begin
            if (st_q.dr) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.rx_buf = rx_data;
                st_d.dr     = 1'b1;
            end
            if (rx_err.brk)     st_d.brk  = 1'b1;
            if (rx_err.parity)  st_d.perr = 1'b1;
            if (rx_err.framing) st_d.ferr = 1'b1;
        end

        st_d.rx_irq = st_q.ctrl.rx_ie && st_d.dr && !st_q.dr;
        st_d.tx_irq = st_q.ctrl.tx_ie && tx_go;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.rxd_sync <= 2'b11;
            st_q.cts_sync <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr)
            W_DATA:  bus_rdata = {{(32-CHAR_W){1'b0}}, st_q.rx_buf};
            W_STAT:  bus_rdata = {25'd0, st_q.ferr, st_q.perr, st_q.ovr, st_q.brk,
                                  !st_q.hold_full, !tx_busy, st_q.dr};
            W_CTRL:  bus_rdata = {{(32-CHAR_W){1'b0}}, st_q.ctrl};
            default: bus_rdata = {{(32-SCALER_W){1'b0}}, st_q.scaler};
        endcase
    end

    assign txd    = st_q.ctrl.loop_en ? 1'b1 : tx_line;
    assign rts_n  = st_q.ctrl.flow_en && st_q.dr;
    assign rx_irq = st_q.rx_irq;
    assign tx_irq = st_q.tx_irq;

    assign loop_en_w   = st_q.ctrl.loop_en;
    assign flow_en_w   = st_q.ctrl.flow_en;
    assign hold_full_w = st_q.hold_full;
    assign dr_w        = st_q.dr;
    assign ovr_w       = st_q.ovr;
    assign rx_buf_w    = st_q.rx_buf;
endmodule

// File: rtl/sio_channel_chk.sv
module sio_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_en,
    input logic       flow_en,
    input logic       txd,
    input logic       rts_n,
    input logic       dr,
    input logic       ovr,
    input logic [7:0] rx_buf,
    input logic       rx_irq,
    input logic       tx_irq,
    input logic       tx_busy
);
    AST_LOOP_TXD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> txd); // R6

    AST_RTS_IDLE_NO_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |-> !rts_n); // R5

    AST_RX_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq); // R12

    AST_RX_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (dr && !$past(dr))); // R12

    AST_OVERRUN_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(rx_buf)); // R10

    AST_TX_IRQ_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> tx_busy); // R12

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd); // R3
endmodule

bind sio_channel sio_channel_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .loop_en (loop_en_w),
    .flow_en (flow_en_w),
    .txd     (txd),
    .rts_n   (rts_n),
    .dr      (dr_w),
    .ovr     (ovr_w),
    .rx_buf  (rx_buf_w),
    .rx_irq  (rx_irq),
    .tx_irq  (tx_irq),
    .tx_busy (u_tx.busy)
);

// File: tb/tb_sio_channel.sv
module tb_sio_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        cts_n = 1'b0;
    logic        txd, rts_n, rx_irq, tx_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int rx_irq_cnt = 0;
    int tx_irq_cnt = 0;
    int scal = 0;

    always #2 clk = ~clk;

    sio_channel dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .cts_n(cts_n), .txd(txd), .rts_n(rts_n),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    always @(negedge clk) begin
        if (rx_irq) rx_irq_cnt++;
        if (tx_irq) tx_irq_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_stat(input string req, input logic [31:0] mask, input logic [31:0] val);
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 4000; i++) begin
            bus_read(2'd1, s);
            if ((s & mask) == val) break;
        end
        chk(req, s & mask, val);
    endtask

    function automatic logic par_bit(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic use_par,
                              input logic pbit, input logic stop);
        int bt;
        bt = 8 * (scal + 1);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (bt) @(negedge clk);
        end
        if (use_par) begin
            rxd = pbit;
            repeat (bt) @(negedge clk);
        end
        rxd = stop;
        repeat (bt) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * bt) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  ch, ch2;
        int          n, ri0, ti0, bad_hi;
        logic        odd, pen;

        void'($urandom(32'd5113));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values and map
        bus_read(2'd0, v); chk("R1 data reset", v, 32'h0);
        bus_read(2'd1, v); chk("R1 status reset", v, 32'h06);
        bus_read(2'd2, v); chk("R1 control reset", v, 32'h0);
        bus_read(2'd3, v); chk("R1 scaler reset", v, 32'h0);
        chk("R3 txd idle high", {31'd0, txd}, 32'd1);
        chk("R5 rts_n low without flow", {31'd0, rts_n}, 32'd0);
        bus_write(2'd2, 32'hA4); bus_read(2'd2, v); chk("R1 control readback", v, 32'hA4);
        bus_write(2'd2, 32'h00);
        scal = 1;
        bus_write(2'd3, 32'd1); bus_read(2'd3, v); chk("R1 scaler readback", v, 32'd1);

        // R4 transmitter disabled holds the character
        bus_write(2'd0, 32'h3C);
        bus_read(2'd1, v); chk("R4 held char status", v & 32'h06, 32'h02);
        bad_hi = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) bad_hi++;
        end
        chk("R4 txd stays high", bad_hi, 0);
        // R3 enable transmitter, watch flags
        bus_write(2'd2, 32'h02);
        repeat (3) @(negedge clk);
        bus_read(2'd1, v); chk("R3 frame in flight", v & 32'h06, 32'h04);
        wait_stat("R3 shifter returns empty", 32'h06, 32'h06);

        // R2 bit timing with scaler 2
        scal = 2;
        bus_write(2'd3, 32'd2);
        bus_write(2'd0, 32'h55);
        while (txd !== 1'b0) @(negedge clk);
        while (txd !== 1'b1) @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        n = 0;
        while (txd === 1'b0 && n < 1000) begin n++; @(negedge clk); end
        chk("R2 bit width clocks", n, 24);
        wait_stat("R2 frame ends", 32'h06, 32'h06);
        scal = 1;
        bus_write(2'd3, 32'd1);

        // R6 R7 R8 R12 random loopback characters
        for (int k = 0; k < 10; k++) begin
            ch  = 8'($urandom);
            pen = 1'($urandom);
            odd = 1'($urandom);
            bus_write(2'd2, {24'd0, 1'b1, 1'b0, pen, odd, 4'hF});
            bus_write(2'd1, 32'h0);
            ri0 = rx_irq_cnt; ti0 = tx_irq_cnt;
            bus_write(2'd0, {24'd0, ch});
            wait_stat("R7 loopback data ready", 32'h01, 32'h01);
            chk("R6 txd pin high in loopback", {31'd0, txd}, 32'd1);
            bus_read(2'd1, v); chk("R8 no error on clean frame", v & 32'h79, 32'h01);
            bus_read(2'd0, v); chk("R6 loopback char", v, {24'd0, ch});
            bus_read(2'd1, v); chk("R7 read clears ready", v & 32'h01, 32'h0);
            chk("R12 one rx_irq pulse", rx_irq_cnt - ri0, 1);
            chk("R12 one tx_irq pulse", tx_irq_cnt - ti0, 1);
            wait_stat("R3 idle after char", 32'h06, 32'h06);
        end

        // R10 R11 overrun
        bus_write(2'd2, 32'h83);
        bus_write(2'd1, 32'h0);
        ch = 8'h4E; ch2 = 8'hB1;
        bus_write(2'd0, {24'd0, ch});
        wait_stat("R10 first char", 32'h01, 32'h01);
        bus_write(2'd0, {24'd0, ch2});
        wait_stat("R10 second frame done", 32'h06, 32'h06);
        bus_read(2'd1, v); chk("R10 overrun flag", v & 32'h11, 32'h11);
        bus_write(2'd1, 32'h10);
        bus_read(2'd1, v); chk("R11 nonzero write ignored", v & 32'h11, 32'h11);
        bus_read(2'd0, v); chk("R10 old char kept", v, {24'd0, ch});
        bus_read(2'd1, v); chk("R10 overrun sticky", v & 32'h11, 32'h10);
        bus_write(2'd1, 32'h0);
        bus_read(2'd1, v); chk("R11 zero write clears", v & 32'h79, 32'h0);

        // R5 flow control
        cts_n = 1'b1;
        bus_write(2'd2, 32'hC3);
        bus_write(2'd0, 32'h9A);
        repeat (300) @(negedge clk);
        bus_read(2'd1, v); chk("R5 waits for cts", v & 32'h06, 32'h02);
        cts_n = 1'b0;
        wait_stat("R5 sent after cts", 32'h01, 32'h01);
        @(negedge clk);
        chk("R5 rts_n high with data ready", {31'd0, rts_n}, 32'd1);
        bus_read(2'd0, v); chk("R5 char after cts", v, 32'h9A);
        @(negedge clk);
        chk("R5 rts_n low after read", {31'd0, rts_n}, 32'd0);
        wait_stat("R5 idle", 32'h06, 32'h06);

        // R7 external receive
        bus_write(2'd2, 32'h01);
        bus_write(2'd1, 32'h0);
        send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
        bus_read(2'd1, v); chk("R7 external ready", v & 32'h79, 32'h01);
        bus_read(2'd0, v); chk("R7 external char", v, 32'h5A);

        // R8 even parity, wrong bit
        bus_write(2'd2, 32'h21);
        bus_write(2'd1, 32'h0);
        send_frame(8'h5A, 1'b1, ~par_bit(8'h5A, 1'b0), 1'b1);
        bus_read(2'd1, v); chk("R8 parity error flagged", v & 32'h79, 32'h21);
        // R8 odd parity, correct bit
        bus_write(2'd2, 32'h31);
        bus_write(2'd1, 32'h0);
        send_frame(8'h33, 1'b1, par_bit(8'h33, 1'b1), 1'b1);
        bus_read(2'd1, v); chk("R8 odd parity accepted", v & 32'h79, 32'h01);
        bus_read(2'd0, v); chk("R8 odd parity char", v, 32'h33);

        // R9 framing and break
        bus_write(2'd2, 32'h01);
        bus_write(2'd1, 32'h0);
        send_frame(8'hA5, 1'b0, 1'b0, 1'b0);
        bus_read(2'd1, v); chk("R9 framing error", v & 32'h49, 32'h41);
        bus_write(2'd1, 32'h0);
        send_frame(8'h00, 1'b0, 1'b0, 1'b0);
        bus_read(2'd1, v); chk("R9 break", v & 32'h49, 32'h09);
        bus_write(2'd1, 32'h0);

        // R7 receiver disabled ignores the line
        bus_write(2'd2, 32'h00);
        ri0 = rx_irq_cnt;
        send_frame(8'h77, 1'b0, 1'b0, 1'b1);
        bus_read(2'd1, v); chk("R7 disabled receiver no ready", v & 32'h79, 32'h0);
        chk("R12 no rx_irq when disabled", rx_irq_cnt - ri0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule